// File: doc/BRIEF.md
# Control Block Specification Checker

This block screens a device control block before an I/O operation is allowed to begin. Once the block words have been fetched, they arrive here as a single beat, together with the context the rules need: the command being started, the line protocol (SDLC or BSC), whether the line is leased or switched, whether a switched connection is already up, and whether an earlier set-mode armed program-controlled interrupts. The block evaluates sixteen legality rules at once and returns one verdict per beat. The verdict says whether the start may proceed or is refused. A refusal sets the specification-check bit of the status byte. The verdict also carries the index of the failing rule, for debug.

The input and the result are both valid/ready streams, and a result register sits between them. A beat is accepted on a clock edge where `in_valid` and `in_ready` are both high. Its verdict appears on the result port in the following cycle. While `res_valid` is high and `res_ready` is low, the verdict and every result field stay frozen and `in_ready` is low, so no beat is lost or overwritten. When the result is consumed on an edge, a new beat can be accepted on that same edge, which gives one verdict per cycle at full rate. The context pins belong to the beat and are sampled only when it is accepted.

Control word bit assignments used by the rules are as follows:
- bit 0: input flag
- bit 1: chain
- bit 2: set-exception
- bit 3: program-controlled interrupt
- bit 4: receive
- bit 5: transmit
- bit 6: disable terminal
- bit 7: enable terminal
- bits 10:8: control operation (1 = auto-answer, 2 = network-information, 3 = set-mode with selection or direct call)
- bit 12: diagnostic wrap
- bits 15:13: storage key

Command codes are as follows:
- 0: start
- 1: start-control
- 2: status read
- 3: diagnostic 1
- 4: diagnostic 2
- 5 to 7: reserved

Top module: `cbc_checker`

## Requirements
- R1: After reset `res_valid` is 0 and `in_ready` is 1. A beat accepted on an edge yields `res_valid`=1 with its verdict after that edge. Reserved command codes 5, 6 and 7 fail with rule 1.
- R2: While `res_valid`=1 and `res_ready`=0, all result fields are held and `in_ready`=0. A result consumed on an edge lets a new beat be accepted on the same edge.
- R3: A passing beat gives `res_start_ok`=1, `res_rule`=0 and `res_status`=8'h00. A failing beat gives `res_start_ok`=0, `res_status`=8'h08 (bit 3 set) and `res_rule` equal to the lowest-numbered failing rule.
- R4: Rule 2 fails when more than one of receive, transmit, disable terminal and enable terminal (control bits 4 to 7) is set, whatever the command.
- R5: Rule 3 fails a status read, diagnostic 1 or diagnostic 2 whose input flag (bit 0) is clear.
- R6: Rule 4 fails a status read whose byte count is not 8 or 12 in SDLC mode (`line_bsc`=0), or not 6 or 10 in BSC mode.
- R7: Rule 5 fails diagnostic 1 unless the count is 16'h0011. Rule 6 fails diagnostic 2 unless the count is 2.
- R8: Rule 7 fails a status read or diagnostic whose data address is odd (bit 0 set).
- R9: Rule 8 fails diagnostic 1 if any control bit outside {0, 13, 14, 15} is set. It fails diagnostic 2 if any control bit outside {0, 12, 13, 14, 15} is set.
- R10: Rule 9 fails a start with receive or transmit set and a byte count of 0.
- R11: Rule 10 fails when the interrupt bit (bit 3) is set without receive or transmit. Rule 11 fails when the interrupt bit is set while `pci_armed`=0.
- R12: For a start-control with operation auto-answer or network-information, the following rules apply:
  - rule 12 fails on a count above 255;
  - rule 13 fails on chain set;
  - rule 14 fails on set-exception clear;
  - rule 15 fails on an odd status address.
- R13: Rule 16 fails a start-control with operation auto-answer, network-information or selection when `line_connected`=1 and `line_leased`=0. The same block on a leased line passes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Control block beat is offered |
| in_ready | output | 1 | Beat will be taken on this edge |
| cmd | input | 3 | Command code of the start being checked |
| line_bsc | input | 1 | 1 = BSC line protocol, 0 = SDLC |
| line_leased | input | 1 | 1 = leased line, 0 = switched |
| line_connected | input | 1 | A switched connection is already established |
| pci_armed | input | 1 | An earlier set-mode enabled interrupt requests |
| ctl_word | input | 16 | Control word of the block |
| stat_addr | input | 16 | Status address word of the block |
| byte_count | input | 16 | Byte count word of the block |
| data_addr | input | 16 | Data address word of the block |
| res_valid | output | 1 | Verdict available |
| res_ready | input | 1 | Consumer takes the verdict on this edge |
| res_start_ok | output | 1 | 1 = operation may start |
| res_rule | output | 5 | Lowest failing rule, 0 when passing |
| res_status | output | 8 | Status byte, bit 3 = specification check |

## Verification
The bench probes every legal and illegal byte count right at its edges. These include both count pairs for status read in each line mode, a count of 255 against 256 for auto-answer, and exactly 0 for a receive start. A checker that swapped the SDLC and BSC pairs, or compared with the wrong relation, would pass a bad count or refuse a good one. Several vectors fail more than one rule at once, so a priority encoder that reported the highest index instead of the lowest would show the wrong rule. A stalled consumer is held off while a second beat waits; a design that let the new beat overwrite the frozen verdict, or dropped the beat when the stall cleared, would show a changed rule or a missing result.

// File: rtl/cbc_pkg.sv
package cbc_pkg;

  localparam int WORD_W    = 16;
  localparam int NUM_RULES = 16;
  localparam int RULE_W    = $clog2(NUM_RULES + 1);
  localparam int OP_W      = 3;

  // command codes
  localparam logic [2:0] CMD_START = 3'd0;
  localparam logic [2:0] CMD_CTRL  = 3'd1;
  localparam logic [2:0] CMD_STAT  = 3'd2;
  localparam logic [2:0] CMD_DIAG1 = 3'd3;
  localparam logic [2:0] CMD_DIAG2 = 3'd4;
  localparam logic [2:0] CMD_LAST  = CMD_DIAG2;

  // control word bit positions
  localparam int CW_IF    = 0;
  localparam int CW_CHAIN = 1;
  localparam int CW_SE    = 2;
  localparam int CW_PCI   = 3;
  localparam int CW_RX    = 4;
  localparam int CW_TX    = 5;
  localparam int CW_DIS   = 6;
  localparam int CW_EN    = 7;
  localparam int CW_OP_LO = 8;

  // control operation codes
  localparam logic [OP_W-1:0] OP_AUTOANS = 3'd1;
  localparam logic [OP_W-1:0] OP_NETINFO = 3'd2;
  localparam logic [OP_W-1:0] OP_SELECT  = 3'd3;

  // exact counts and masks
  localparam logic [WORD_W-1:0] DIAG1_MASK  = 16'hE001;
  localparam logic [WORD_W-1:0] DIAG2_MASK  = 16'hF001;
  localparam logic [WORD_W-1:0] DIAG1_COUNT = 16'h0011;
  localparam logic [WORD_W-1:0] DIAG2_COUNT = 16'h0002;
  localparam logic [WORD_W-1:0] SDLC_CNT_A  = 16'd8;
  localparam logic [WORD_W-1:0] SDLC_CNT_B  = 16'd12;
  localparam logic [WORD_W-1:0] BSC_CNT_A   = 16'd6;
  localparam logic [WORD_W-1:0] BSC_CNT_B   = 16'd10;
  localparam logic [WORD_W-1:0] LINK_CNT_MAX = 16'd255;

  localparam int STAT_SPEC_BIT = 3;

  typedef struct packed {
    logic                  in_flag;
    logic                  chain;
    logic                  set_exc;
    logic                  pci;
    logic                  rx;
    logic                  tx;
    logic                  dis;
    logic                  en;
    logic [OP_W-1:0]       op;
    logic [WORD_W-1:0]     raw;
  } ctl_t;

endpackage

// File: rtl/cbc_fields.sv
module cbc_fields
  import cbc_pkg::*;
(
  input  logic [WORD_W-1:0] ctl_word,
  input  logic [WORD_W-1:0] stat_addr,
  input  logic [WORD_W-1:0] data_addr,
  output ctl_t              ctl,
  output logic              saddr_odd,
  output logic              daddr_odd
);

  // only the alignment of the addresses matters to the rules
  logic addr_hi_unused;
  assign addr_hi_unused = ^{stat_addr[WORD_W-1:1], data_addr[WORD_W-1:1]};

  always_comb begin
    ctl.in_flag = ctl_word[CW_IF];
    ctl.chain   = ctl_word[CW_CHAIN];
    ctl.set_exc = ctl_word[CW_SE];
    ctl.pci     = ctl_word[CW_PCI];
    ctl.rx      = ctl_word[CW_RX];
    ctl.tx      = ctl_word[CW_TX];
    ctl.dis     = ctl_word[CW_DIS];
    ctl.en      = ctl_word[CW_EN];
    ctl.op      = ctl_word[CW_OP_LO +: OP_W];
    ctl.raw     = ctl_word;
  end

  assign saddr_odd = stat_addr[0];
  assign daddr_odd = data_addr[0];

endmodule

// File: rtl/cbc_rules.sv
module cbc_rules
  import cbc_pkg::*;
(
  input  logic [2:0]           cmd,
  input  logic                 line_bsc,
  input  logic                 line_leased,
  input  logic                 line_connected,
  input  logic                 pci_armed,
  input  ctl_t                 ctl,
  input  logic [WORD_W-1:0]    count,
  input  logic                 saddr_odd,
  input  logic                 daddr_odd,
  output logic [NUM_RULES-1:0] fail
);

  logic is_start, is_ctrl, is_stat, is_d1, is_d2, needs_in;
  logic stat_cnt_ok, xfer, link_op, switched_op;

  always_comb begin
    is_start = (cmd == CMD_START);
    is_ctrl  = (cmd == CMD_CTRL);
    is_stat  = (cmd == CMD_STAT);
    is_d1    = (cmd == CMD_DIAG1);
    is_d2    = (cmd == CMD_DIAG2);
    needs_in = is_stat | is_d1 | is_d2;
    xfer     = ctl.rx | ctl.tx;

    if (line_bsc) stat_cnt_ok = (count == BSC_CNT_A)  || (count == BSC_CNT_B);
    else          stat_cnt_ok = (count == SDLC_CNT_A) || (count == SDLC_CNT_B);

    link_op     = is_ctrl && ((ctl.op == OP_AUTOANS) || (ctl.op == OP_NETINFO));
    switched_op = is_ctrl && ((ctl.op == OP_AUTOANS) || (ctl.op == OP_NETINFO) ||
                              (ctl.op == OP_SELECT));

    // bit k carries rule k+1
    fail[0]  = cmd > CMD_LAST;
    fail[1]  = $countones({ctl.rx, ctl.tx, ctl.dis, ctl.en}) > 1;
    fail[2]  = needs_in && !ctl.in_flag;
    fail[3]  = is_stat && !stat_cnt_ok;
    fail[4]  = is_d1 && (count != DIAG1_COUNT);
    fail[5]  = is_d2 && (count != DIAG2_COUNT);
    fail[6]  = needs_in && daddr_odd;
    fail[7]  = (is_d1 && |(ctl.raw & ~DIAG1_MASK)) ||
               (is_d2 && |(ctl.raw & ~DIAG2_MASK));
    fail[8]  = is_start && xfer && (count == '0);
    fail[9]  = ctl.pci && !xfer;
    fail[10] = ctl.pci && !pci_armed;
    fail[11] = link_op && (count > LINK_CNT_MAX);
    fail[12] = link_op && ctl.chain;
    fail[13] = link_op && !ctl.set_exc;
    fail[14] = link_op && saddr_odd;
    fail[15] = switched_op && line_connected && !line_leased;
  end

endmodule

// File: rtl/cbc_prio.sv
module cbc_prio #(
  parameter int N = 16,
  parameter int W = $clog2(N + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  output logic [W-1:0] idx
);

  always_comb begin
    idx = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (req[k]) idx = W'(k + 1);
    end
  end

  AST_PRIO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (|req) |-> (idx != '0) && req[idx - W'(1)]);  // R3
  AST_PRIO_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    !(|req) |-> (idx == '0));  // R3

endmodule

// File: rtl/cbc_checker.sv
module cbc_checker
  import cbc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [2:0]        cmd,
  input  logic              line_bsc,
  input  logic              line_leased,
  input  logic              line_connected,
  input  logic              pci_armed,
  input  logic [WORD_W-1:0] ctl_word,
  input  logic [WORD_W-1:0] stat_addr,
  input  logic [WORD_W-1:0] byte_count,
  input  logic [WORD_W-1:0] data_addr,
  output logic              res_valid,
  input  logic              res_ready,
  output logic              res_start_ok,
  output logic [RULE_W-1:0] res_rule,
  output logic [7:0]        res_status
);

  ctl_t                 ctl;
  logic                 saddr_odd, daddr_odd;
  logic [NUM_RULES-1:0] fail;
  logic [RULE_W-1:0]    rule_idx;
  logic                 accept;

  cbc_fields u_fields (
    .ctl_word  (ctl_word),
    .stat_addr (stat_addr),
    .data_addr (data_addr),
    .ctl       (ctl),
    .saddr_odd (saddr_odd),
    .daddr_odd (daddr_odd)
  );

  cbc_rules u_rules (
    .cmd            (cmd),
    .line_bsc       (line_bsc),
    .line_leased    (line_leased),
    .line_connected (line_connected),
    .pci_armed      (pci_armed),
    .ctl            (ctl),
    .count          (byte_count),
    .saddr_odd      (saddr_odd),
    .daddr_odd      (daddr_odd),
    .fail           (fail)
  );

  cbc_prio #(.N(NUM_RULES), .W(RULE_W)) u_prio (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (fail),
    .idx   (rule_idx)
  );

  assign in_ready = !res_valid || res_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid    <= 1'b0;
      res_start_ok <= 1'b0;
      res_rule     <= '0;
      res_status   <= '0;
    end else if (accept) begin
      res_valid    <= 1'b1;
      res_start_ok <= ~|fail;
      res_rule     <= rule_idx;
      res_status   <= 8'(|fail) << STAT_SPEC_BIT;
    end else if (res_ready) begin
      res_valid    <= 1'b0;
    end
  end

  AST_ACCEPT_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> res_valid);  // R1
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_rule) &&
                                $stable(res_status) && $stable(res_start_ok));  // R2
  AST_VERDICT_CONSISTENT: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_status[STAT_SPEC_BIT] != res_start_ok) &&
                  (res_start_ok == (res_rule == '0)));  // R3
  AST_STAT_SDLC_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (cmd == CMD_STAT) && !line_bsc &&
    (byte_count != SDLC_CNT_A) && (byte_count != SDLC_CNT_B)
    |=> !res_start_ok);  // R6
  AST_DIAG1_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (cmd == CMD_DIAG1) && (byte_count != DIAG1_COUNT)
    |=> !res_start_ok);  // R7
  AST_SWITCHED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (cmd == CMD_CTRL) && (ctl_word[CW_OP_LO +: OP_W] == OP_AUTOANS) &&
    line_connected && !line_leased |=> !res_start_ok);  // R13

endmodule

// File: tb/test_cbc_checker.sv
`timescale 1ns/1ps
module test_cbc_checker;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  cmd = '0;
  logic        line_bsc = 1'b0, line_leased = 1'b0, line_connected = 1'b0, pci_armed = 1'b0;
  logic [15:0] ctl_word = '0, stat_addr = '0, byte_count = '0, data_addr = '0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic        res_start_ok;
  logic [4:0]  res_rule;
  logic [7:0]  res_status;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  cbc_checker i_cbc_checker (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .cmd(cmd), .line_bsc(line_bsc), .line_leased(line_leased),
    .line_connected(line_connected), .pci_armed(pci_armed),
    .ctl_word(ctl_word), .stat_addr(stat_addr), .byte_count(byte_count),
    .data_addr(data_addr), .res_valid(res_valid), .res_ready(res_ready),
    .res_start_ok(res_start_ok), .res_rule(res_rule), .res_status(res_status)
  );

  typedef struct packed {
    logic [2:0]  cmd;
    logic        bsc;
    logic        leased;
    logic        conn;
    logic        armed;
    logic [15:0] cw;
    logic [15:0] saddr;
    logic [15:0] cnt;
    logic [15:0] daddr;
    logic [4:0]  rule;
  } vec_t;

  localparam int NV = 35;
  localparam vec_t VECS [NV] = '{
    '{3'd2,1'b0,1'b0,1'b0,1'b0,16'h0001,16'h0000,16'd8,  16'h0100,5'd0},  // R6 sdlc 8
    '{3'd2,1'b0,1'b0,1'b0,1'b0,16'h0001,16'h0000,16'd12, 16'h0100,5'd0},  // R6 sdlc 12
    '{3'd2,1'b0,1'b0,1'b0,1'b0,16'h0001,16'h0000,16'd6,  16'h0100,5'd4},  // R6 sdlc 6
    '{3'd2,1'b1,1'b0,1'b0,1'b0,16'h0001,16'h0000,16'd6,  16'h0100,5'd0},  // R6 bsc 6
    '{3'd2,1'b1,1'b0,1'b0,1'b0,16'h0001,16'h0000,16'd10, 16'h0100,5'd0},  // R6 bsc 10
    '{3'd2,1'b1,1'b0,1'b0,1'b0,16'h0001,16'h0000,16'd8,  16'h0100,5'd4},  // R6 bsc 8
    '{3'd2,1'b0,1'b0,1'b0,1'b0,16'h0000,16'h0000,16'd8,  16'h0100,5'd3},  // R5
    '{3'd2,1'b0,1'b0,1'b0,1'b0,16'h0001,16'h0000,16'd8,  16'h0101,5'd7},  // R8
    '{3'd3,1'b0,1'b0,1'b0,1'b0,16'hE001,16'h0000,16'h0011,16'h0100,5'd0}, // R7 diag1 ok
    '{3'd3,1'b0,1'b0,1'b0,1'b0,16'hE001,16'h0000,16'h0010,16'h0100,5'd5}, // R7
    '{3'd4,1'b0,1'b0,1'b0,1'b0,16'hF001,16'h0000,16'd2,  16'h0100,5'd0},  // R7 diag2 ok
    '{3'd4,1'b0,1'b0,1'b0,1'b0,16'hF001,16'h0000,16'd3,  16'h0100,5'd6},  // R7
    '{3'd3,1'b0,1'b0,1'b0,1'b0,16'hF001,16'h0000,16'h0011,16'h0100,5'd8}, // R9
    '{3'd4,1'b0,1'b0,1'b0,1'b0,16'hF005,16'h0000,16'd2,  16'h0100,5'd8},  // R9
    '{3'd3,1'b0,1'b0,1'b0,1'b0,16'hE001,16'h0000,16'h0011,16'h0201,5'd7}, // R8
    '{3'd0,1'b0,1'b0,1'b0,1'b0,16'h0010,16'h0000,16'd0,  16'h0100,5'd9},  // R10
    '{3'd0,1'b0,1'b0,1'b0,1'b0,16'h0020,16'h0000,16'd4,  16'h0100,5'd0},  // R10 ok
    '{3'd0,1'b0,1'b0,1'b0,1'b0,16'h0030,16'h0000,16'd4,  16'h0100,5'd2},  // R4
    '{3'd0,1'b0,1'b0,1'b0,1'b0,16'h00C0,16'h0000,16'd4,  16'h0100,5'd2},  // R4
    '{3'd0,1'b0,1'b0,1'b0,1'b1,16'h0018,16'h0000,16'd4,  16'h0100,5'd0},  // R11 ok
    '{3'd0,1'b0,1'b0,1'b0,1'b0,16'h0018,16'h0000,16'd4,  16'h0100,5'd11}, // R11
    '{3'd0,1'b0,1'b0,1'b0,1'b1,16'h0048,16'h0000,16'd4,  16'h0100,5'd10}, // R11
    '{3'd1,1'b0,1'b0,1'b0,1'b0,16'h0104,16'h0300,16'd255,16'h0100,5'd0},  // R12 ok
    '{3'd1,1'b0,1'b0,1'b0,1'b0,16'h0104,16'h0300,16'd256,16'h0100,5'd12}, // R12
    '{3'd1,1'b0,1'b0,1'b0,1'b0,16'h0106,16'h0300,16'd16, 16'h0100,5'd13}, // R12
    '{3'd1,1'b0,1'b0,1'b0,1'b0,16'h0200,16'h0300,16'd16, 16'h0100,5'd14}, // R12
    '{3'd1,1'b0,1'b0,1'b0,1'b0,16'h0204,16'h0301,16'd16, 16'h0100,5'd15}, // R12
    '{3'd1,1'b0,1'b0,1'b1,1'b0,16'h0104,16'h0300,16'd16, 16'h0100,5'd16}, // R13
    '{3'd1,1'b0,1'b1,1'b1,1'b0,16'h0104,16'h0300,16'd16, 16'h0100,5'd0},  // R13 leased
    '{3'd1,1'b0,1'b0,1'b1,1'b0,16'h0300,16'h0300,16'd16, 16'h0100,5'd16}, // R13
    '{3'd1,1'b0,1'b0,1'b0,1'b0,16'h0300,16'h0300,16'd16, 16'h0100,5'd0},  // R13 idle
    '{3'd5,1'b0,1'b0,1'b0,1'b0,16'h0000,16'h0000,16'd0,  16'h0000,5'd1},  // R1
    '{3'd7,1'b0,1'b0,1'b0,1'b0,16'h0000,16'h0000,16'd0,  16'h0000,5'd1},  // R1
    '{3'd2,1'b0,1'b0,1'b0,1'b0,16'h0030,16'h0000,16'd7,  16'h0101,5'd2},  // R3 priority
    '{3'd0,1'b0,1'b0,1'b0,1'b0,16'h0018,16'h0000,16'd0,  16'h0100,5'd9}   // R3 priority
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic load(input vec_t v);
    cmd = v.cmd; line_bsc = v.bsc; line_leased = v.leased;
    line_connected = v.conn; pci_armed = v.armed;
    ctl_word = v.cw; stat_addr = v.saddr; byte_count = v.cnt; data_addr = v.daddr;
  endtask

  task automatic check_verdict(input string req, input logic [4:0] rule);
    chk(res_valid == 1'b1, req, "res_valid", int'(res_valid), 1);
    chk(res_rule == rule, req, "res_rule", int'(res_rule), int'(rule));
    chk(res_start_ok == (rule == 5'd0), req, "res_start_ok",
        int'(res_start_ok), int'(rule == 5'd0));
    chk(res_status == ((rule == 5'd0) ? 8'h00 : 8'h08), req, "res_status",
        int'(res_status), (rule == 5'd0) ? 0 : 8);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(res_valid == 1'b0, "R1", "reset res_valid", int'(res_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R1", "idle in_ready", int'(in_ready), 1);
    chk(res_valid == 1'b0, "R1", "idle res_valid", int'(res_valid), 0);

    // table walk: one beat per vector, verdict checked the cycle after acceptance
    for (int i = 0; i < NV; i++) begin
      load(VECS[i]);
      in_valid = 1'b1;
      @(posedge clk);
      #1 in_valid = 1'b0;
      @(negedge clk);
      check_verdict($sformatf("R3 vec%0d", i), VECS[i].rule);
    end
    @(negedge clk);
    chk(res_valid == 1'b0, "R1", "drained res_valid", int'(res_valid), 0);

    // R2 back-pressure: failing verdict held while a passing beat waits
    res_ready = 1'b0;
    load(VECS[2]);
    in_valid = 1'b1;
    @(posedge clk);
    #1 load(VECS[0]);
    @(negedge clk);
    check_verdict("R2 stalled", 5'd4);
    chk(in_ready == 1'b0, "R2", "stalled in_ready", int'(in_ready), 0);
    repeat (2) @(posedge clk);
    @(negedge clk);
    check_verdict("R2 still stalled", 5'd4);
    chk(in_ready == 1'b0, "R2", "still stalled in_ready", int'(in_ready), 0);
    res_ready = 1'b1;
    @(posedge clk);
    #1 in_valid = 1'b0;
    @(negedge clk);
    check_verdict("R2 same-edge refill", 5'd0);
    @(posedge clk);
    @(negedge clk);
    chk(res_valid == 1'b0, "R2", "after drain res_valid", int'(res_valid), 0);

    // R1: reset clears a pending verdict
    load(VECS[31]);
    in_valid = 1'b1;
    @(posedge clk);
    #1 in_valid = 1'b0;
    rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk(res_valid == 1'b0, "R1", "reset flush res_valid", int'(res_valid), 0);
    rst_n = 1'b1;

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule